// File: doc/BRIEF.md
# Completion Interrupt Moderation Timer Pair

This block holds back the completion interrupt of one data direction so that a burst of completions produces one interrupt instead of many. Two counters decide when the held interrupt is released. The burst counter is armed by the first completion after the last interrupt and limits how long that completion can wait. The gap counter restarts on every completion and releases the interrupt once the completion stream has been quiet for a set time. Whichever counter reaches its limit first produces a one-cycle interrupt pulse, and both counters then stand down until the next completion.

Each counter is configured through a control word and a limit word on a small register port. The control word holds an enable, a selector that makes the counter advance on an external microsecond strobe instead of on every clock, and a self-clearing stop bit that software writes before it changes a limit. When both counters are disabled, the block forwards every completion as an interrupt with one register of delay.

Top module: `irq_moderation_pair`

## Requirements
- R1: The register port decodes `reg_addr` as 0 = burst control, 1 = burst limit, 2 = gap control, 3 = gap limit. Control bit 0 is the stop bit, bit 1 the enable and bit 2 the tick selector. A read with `reg_rd` high returns the addressed word on `reg_rdata` after the next clock edge; a control word reads back as {tick selector, enable, 0} in bits 2:0 with all higher bits zero.
- R2: After reset every control and limit word reads zero and `irq_pulse` is low.
- R3: A control write with bit 0 set stores enable as 0 whatever bit 1 holds, stops that counter at once and drops its count, so it raises no interrupt afterwards.
- R4: A counter whose tick selector is 1 advances only on clock edges where `us_tick` is high; with the selector at 0 it advances on every edge.
- R5: The burst counter starts from zero on a completion while it is stopped; completions that arrive while it is running neither restart nor pause it.
- R6: The gap counter restarts from zero on every completion.
- R7: A counter fires on the counting event at which its count equals its limit (count is 0 at the first event after the start), so an enabled counter with limit N fires N+1 counting events after the completion; `irq_pulse` is then high for exactly one cycle and both counters go idle, with no further pulse until a new completion.
- R8: With both enables at 0, each completion sampled on an edge raises `irq_pulse` after that same edge.
- R9: A limit of zero fires on the first counting event after the completion.
- R10: `irq_pulse` is a register output: a moderated pulse appears on the clock edge of the firing event, so in clock-count mode the latency from the completion edge is limit+1 cycles and in tick mode it is (limit+1) tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data, valid one edge after reg_rd |
| cmpl_pulse | input | 1 | Raw completion event, one cycle per completion |
| us_tick | input | 1 | External microsecond strobe, one cycle wide |
| irq_pulse | output | 1 | Moderated interrupt pulse |

## Verification
The assertions take completions and ticks to be synchronous one-cycle levels, and they exempt cycles that carry a register write, because a write may legally stop a counter or move its enable on the same edge. The stimulus respects this by driving every input half a cycle away from the sampling edge and by doing all configuration before the completion that opens a measurement, never writing a limit while a counter runs. Tick-mode cases drive the strobe at a fixed period counted from the completion edge, so the expected latency follows directly from the limits and that period.

// File: rtl/imod_pkg.sv
package imod_pkg;

  localparam int NUM_CTR   = 2;
  localparam int BURST_IDX = 0;
  localparam int GAP_IDX   = 1;

  // reg_addr[1] picks the counter, reg_addr[0] picks control (0) or limit (1)
  localparam int ADDR_W = 2;

  localparam int CTL_STOP_BIT = 0;
  localparam int CTL_EN_BIT   = 1;
  localparam int CTL_TSEL_BIT = 2;

endpackage

// File: rtl/imod_regs.sv
module imod_regs
  import imod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            reg_wr,
  input  logic                            reg_rd,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [CNT_W-1:0]                reg_wdata,
  output logic [CNT_W-1:0]                reg_rdata,
  output logic [NUM_CTR-1:0]              ctr_en,
  output logic [NUM_CTR-1:0]              ctr_tsel,
  output logic [NUM_CTR-1:0]              ctr_stop,
  output logic [NUM_CTR-1:0][CNT_W-1:0]   ctr_lim
);

  localparam int SEL_W = $clog2(NUM_CTR);

  logic [SEL_W-1:0] ctr_sel;
  logic             is_lim;

  assign ctr_sel = reg_addr[ADDR_W-1 -: SEL_W];
  assign is_lim  = reg_addr[0];

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_reg
    logic             hit_ctl;
    logic             hit_lim;
    logic             en_q;
    logic             tsel_q;
    logic [CNT_W-1:0] lim_q;

    assign hit_ctl = reg_wr && (ctr_sel == SEL_W'(g)) && !is_lim;
    assign hit_lim = reg_wr && (ctr_sel == SEL_W'(g)) &&  is_lim;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= 1'b0;
        tsel_q <= 1'b0;
        lim_q  <= '0;
      end else begin
        if (hit_ctl) begin
          en_q   <= reg_wdata[CTL_EN_BIT] && !reg_wdata[CTL_STOP_BIT];
          tsel_q <= reg_wdata[CTL_TSEL_BIT];
        end
        if (hit_lim) begin
          lim_q <= reg_wdata;
        end
      end
    end

    assign ctr_en[g]   = en_q;
    assign ctr_tsel[g] = tsel_q;
    assign ctr_lim[g]  = lim_q;
    assign ctr_stop[g] = hit_ctl && reg_wdata[CTL_STOP_BIT];
  end

  logic [CNT_W-1:0] ctl_word;

  always_comb begin
    ctl_word                = '0;
    ctl_word[CTL_EN_BIT]    = ctr_en[ctr_sel];
    ctl_word[CTL_TSEL_BIT]  = ctr_tsel[ctr_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= is_lim ? ctr_lim[ctr_sel] : ctl_word;
    end
  end

endmodule

// File: rtl/imod_counter.sv
module imod_counter #(
  parameter int CNT_W        = 16,
  parameter bit RESTART_EACH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tick_sel,
  input  logic             stop,
  input  logic [CNT_W-1:0] limit,
  input  logic             us_tick,
  input  logic             cmpl,
  input  logic             fire_any,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             fire
);

  logic step;
  logic start;

  assign step = tick_sel ? us_tick : 1'b1;
  assign fire = enable && running && step && (count >= limit);

  if (RESTART_EACH) begin : g_restart
    assign start = cmpl;
  end else begin : g_hold
    assign start = cmpl && (!running || fire_any);
  end

  always_ff @(posedge clk) begin
    if (rst || stop || !enable) begin
      running <= 1'b0;
      count   <= '0;
    end else if (start) begin
      running <= 1'b1;
      count   <= '0;
    end else if (fire_any) begin
      running <= 1'b0;
      count   <= '0;
    end else if (running && step) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/irq_moderation_pair.sv
module irq_moderation_pair
  import imod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cmpl_pulse,
  input  logic              us_tick,
  output logic              irq_pulse
);

  logic [NUM_CTR-1:0]            ctr_en;
  logic [NUM_CTR-1:0]            ctr_tsel;
  logic [NUM_CTR-1:0]            ctr_stop;
  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_lim;
  logic [NUM_CTR-1:0]            ctr_run;
  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_cnt;
  logic [NUM_CTR-1:0]            ctr_fire;
  logic                          fire_any;
  logic                          bypass;

  imod_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctr_en    (ctr_en),
    .ctr_tsel  (ctr_tsel),
    .ctr_stop  (ctr_stop),
    .ctr_lim   (ctr_lim)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    imod_counter #(
      .CNT_W        (CNT_W),
      .RESTART_EACH (g == GAP_IDX)
    ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .enable   (ctr_en[g]),
      .tick_sel (ctr_tsel[g]),
      .stop     (ctr_stop[g]),
      .limit    (ctr_lim[g]),
      .us_tick  (us_tick),
      .cmpl     (cmpl_pulse),
      .fire_any (fire_any),
      .running  (ctr_run[g]),
      .count    (ctr_cnt[g]),
      .fire     (ctr_fire[g])
    );
  end

  assign fire_any = |ctr_fire;
  assign bypass   = ~|ctr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= bypass ? cmpl_pulse : fire_any;
    end
  end

endmodule

// File: rtl/imod_checker.sv
module imod_checker #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic [1:0]            reg_addr,
  input logic [CNT_W-1:0]      reg_wdata,
  input logic                  cmpl_pulse,
  input logic                  us_tick,
  input logic [1:0]            en,
  input logic [1:0]            tsel,
  input logic [1:0]            run,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic                  fire_any,
  input logic                  irq_pulse
);

  // R3: a stop write halts the burst counter on the next edge
  assert_burst_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> !run[0]);

  // R3: a stop write halts the gap counter on the next edge
  assert_gap_stop_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd2 && reg_wdata[0]) |=> !run[1]);

  // R4: in tick mode the gap counter holds without a strobe
  assert_tick_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (run[1] && en[1] && tsel[1] && !us_tick && !cmpl_pulse && !fire_any && !reg_wr)
      |=> $stable(cnt[1]));

  // R5: a completion during a burst window neither restarts nor stops it
  assert_burst_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (run[0] && en[0] && tsel[0] && !us_tick && cmpl_pulse && !fire_any && !reg_wr)
      |=> (run[0] && $stable(cnt[0])));

  // R6: every completion restarts the gap counter at zero
  assert_gap_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (en[1] && cmpl_pulse && !reg_wr) |=> (run[1] && cnt[1] == '0));

  // R8: with both counters disabled a completion is forwarded
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (en == 2'b00 && cmpl_pulse) |=> irq_pulse);

endmodule

bind irq_moderation_pair imod_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .cmpl_pulse (cmpl_pulse),
  .us_tick    (us_tick),
  .en         (ctr_en),
  .tsel       (ctr_tsel),
  .run        (ctr_run),
  .cnt        (ctr_cnt),
  .fire_any   (fire_any),
  .irq_pulse  (irq_pulse)
);

// File: tb/tb_irq_moderation_pair.sv
module tb_irq_moderation_pair;

  localparam int CNT_W  = 16;
  localparam int NVEC   = 8;
  localparam int NONE   = 100000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [CNT_W-1:0] reg_wdata = '0;
  logic [CNT_W-1:0] reg_rdata;
  logic             cmpl_pulse = 1'b0;
  logic             us_tick = 1'b0;
  logic             irq_pulse;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_moderation_pair #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmpl_pulse(cmpl_pulse), .us_tick(us_tick), .irq_pulse(irq_pulse)
  );

  // burst_en, burst_tsel, burst_lim, gap_en, gap_tsel, gap_lim, tick_period
  localparam int VEC [NVEC][7] = '{
    '{1, 0, 5, 1, 0, 9, 4},
    '{1, 0, 9, 1, 0, 3, 4},
    '{0, 0, 0, 0, 0, 0, 4},
    '{1, 1, 2, 0, 0, 0, 4},
    '{0, 0, 0, 1, 1, 1, 3},
    '{1, 0, 0, 1, 0, 7, 4},
    '{0, 0, 0, 1, 1, 0, 5},
    '{1, 1, 3, 1, 0, 30, 2}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = CNT_W'(d);
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output int d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  // control word: bit0 stop, bit1 enable, bit2 tick select
  task automatic configure(input int be, input int bt, input int bl,
                           input int ge, input int gt, input int gl);
    reg_write(2'd0, 1);
    reg_write(2'd2, 1);
    reg_write(2'd1, bl);
    reg_write(2'd3, gl);
    reg_write(2'd0, (bt << 2) | (be << 1));
    reg_write(2'd2, (gt << 2) | (ge << 1));
  endtask

  function automatic int ctr_lat(input int en, input int ts, input int lim, input int per);
    if (en == 0) return NONE;
    return (lim + 1) * ((ts != 0) ? per : 1);
  endfunction

  // one completion, then edges counted until irq_pulse is seen
  task automatic measure(input int per, input int maxc, output int lat, output int width_ok);
    lat = -1;
    cmpl_pulse = 1'b1;
    @(posedge clk); @(negedge clk);
    cmpl_pulse = 1'b0;
    if (irq_pulse) lat = 0;
    for (int i = 1; i <= maxc && lat < 0; i++) begin
      us_tick = (per > 0) && (i % per == 0);
      @(posedge clk); @(negedge clk);
      us_tick = 1'b0;
      if (irq_pulse) lat = i;
    end
    @(posedge clk); @(negedge clk);
    width_ok = irq_pulse ? 0 : 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int rd, lat, wok, exp, quiet;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R2: reset state
    check("R2 irq after reset", int'(irq_pulse), 0);
    for (int a = 0; a < 4; a++) begin
      reg_read(2'(a), rd);
      check("R2 register reset value", rd, 0);
    end

    // R1: decode and readback
    reg_write(2'd1, 16'h1234);
    reg_write(2'd2, 6);
    reg_read(2'd1, rd);  check("R1 burst limit readback", rd, 16'h1234);
    reg_read(2'd2, rd);  check("R1 gap control readback", rd, 6);
    // R3: stop bit forces enable low
    reg_write(2'd2, 7);
    reg_read(2'd2, rd);  check("R3 stop clears enable", rd, 4);

    // vector table: R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      configure(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      if (VEC[v][0] == 0 && VEC[v][3] == 0) exp = 0;
      else begin
        exp = ctr_lat(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][6]);
        if (ctr_lat(VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]) < exp)
          exp = ctr_lat(VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      end
      measure(VEC[v][6], 80, lat, wok);
      check($sformatf("R10 R4 R8 R9 latency vector %0d", v), lat, exp);
      check($sformatf("R7 single-cycle pulse vector %0d", v), wok, 1);
    end

    // R7: no further pulse without a new completion
    quiet = 1;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_pulse) quiet = 0;
    end
    check("R7 quiet after fire", quiet, 1);

    // R3: stop write during a burst window suppresses the pulse
    configure(1, 0, 10, 0, 0, 0);
    cmpl_pulse = 1'b1;
    @(posedge clk); @(negedge clk);
    cmpl_pulse = 1'b0;
    @(posedge clk); @(negedge clk);
    reg_write(2'd0, 3);
    quiet = 1;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_pulse) quiet = 0;
    end
    check("R3 stopped counter stays silent", quiet, 1);

    // R5 R6: completions every 3 cycles keep the gap counter from firing
    // and leave the burst window running; expect burst latency 21
    configure(1, 0, 20, 1, 0, 5);
    lat = -1;
    cmpl_pulse = 1'b1;
    @(posedge clk); @(negedge clk);
    cmpl_pulse = 1'b0;
    for (int i = 1; i <= 60 && lat < 0; i++) begin
      cmpl_pulse = (i % 3 == 0);
      @(posedge clk); @(negedge clk);
      cmpl_pulse = 1'b0;
      if (irq_pulse) lat = i;
    end
    check("R5 R6 burst bound under steady completions", lat, 21);
    repeat (30) @(posedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule